// File: doc/BRIEF.md
# Dual-Reset System Control Register Bank

This block holds a handful of system-control registers whose reset values depend on which reset is applied. A cold reset, asserted after power-up, puts every field into a known state. A soft reset is for a device that is already running. It sets the mode bits needed to restart safely, marks that a soft restart took place, and leaves the power and watchpoint settings that software already programmed as they were.

The bank has five registers. The status register holds the boot-vector select, error level, soft-restart flag, NMI flag, TLB-shutdown flag and low-power bits. There is a replacement index that counts down on every clock between a software-set wired floor and a parameterised maximum, and a wired register that sets that floor. The configuration register combines a writable kseg0 cacheability field with a copy of the static configuration pins. The fifth register holds three watchpoint enables (instruction, read, write). Software reaches all of them through a single-cycle write port and a combinational read port.

Both resets and all writes are synchronous to `clk`. When both resets are high together, the cold reset takes precedence.

Top module: `ctl_regbank`

## Requirements
- R1: On a cycle with cold reset high, the status register (address 0) is loaded with boot-vector bit0=1, error-level bit1=1, and soft-flag bit2, NMI bit3, TLB-shutdown bit4 and low-power bit5 all 0, so it reads 0x03.
- R2: On a cycle with soft reset high and cold reset low, status bits 0, 1 and 2 become 1 and bits 3 and 4 become 0, while low-power bit5 keeps its previous value.
- R3: Either reset loads the replacement index (address 1) with MAX_IDX and the wired register (address 2) with 0.
- R4: On every cycle with neither reset high and no wired write, the index becomes MAX_IDX if it is less than or equal to the wired value, and otherwise decrements by 1.
- R5: A write to address 2 stores the low IDX_W bits of the write data as the wired value and reloads the index with MAX_IDX on the same edge. Writes to address 1 have no effect.
- R6: Cold reset clears the watch enables (address 4, bits 2:0). Soft reset leaves them unchanged.
- R7: Cold reset sets the cacheability field (address 3, bits 2:0) to 3'b010, and soft reset leaves it unchanged. Bits [CFG_W+2:3] of address 3 take the value of `cfg_pins` on every edge where either reset is high, and otherwise keep their value whatever the pins do.
- R8: When cold reset and soft reset are high together, every field takes its cold-reset value, so the soft flag is 0 and low-power and the watch enables are cleared.
- R9: Outside reset, a write to address 0 (bits 5:0), address 3 (bits 2:0) or address 4 (bits 2:0) shows on the read port from the next cycle on. Addresses 5 to 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cold_rst | input | 1 | Synchronous power-up reset, active high, highest priority |
| soft_rst | input | 1 | Synchronous warm reset, active high |
| cfg_pins | input | CFG_W | Static configuration pins, captured only while a reset is high |
| sw_we | input | 1 | Software write strobe |
| sw_addr | input | 3 | Register address for both read and write |
| sw_wdata | input | 32 | Write data |
| sw_rdata | output | 32 | Read data for `sw_addr`, zero-extended |

## Verification
The bench builds the block with MAX_IDX = 11 and IDX_W = 4. Because 11 is not a power of two, a wrap that falls back to the all-ones value of the counter shows up as a mismatch, and a random wired floor between 0 and 11 produces short counting periods that wrap many times within a few hundred cycles. CFG_W = 4 places the pin copy at bits 6:3, right next to the cacheability field, so a wrong slice or an unwanted capture outside reset is visible on the read port.

// File: rtl/ctl_pkg.sv
package ctl_pkg;

  localparam int ADDR_W = 3;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] A_STATUS = 3'd0;
  localparam logic [ADDR_W-1:0] A_INDEX  = 3'd1;
  localparam logic [ADDR_W-1:0] A_WIRED  = 3'd2;
  localparam logic [ADDR_W-1:0] A_CONFIG = 3'd3;
  localparam logic [ADDR_W-1:0] A_WATCH  = 3'd4;

  localparam logic [2:0] K0_UNCACHED = 3'b010;

  // bit0 boot_vec ... bit5 low_pwr
  typedef struct packed {
    logic low_pwr;
    logic tlb_shut;
    logic nmi_flag;
    logic soft_flag;
    logic err_lvl;
    logic boot_vec;
  } status_t;

  localparam int STATUS_W = $bits(status_t);

  function automatic status_t status_cold();
    status_t s;
    s = '0;
    s.boot_vec = 1'b1;
    s.err_lvl  = 1'b1;
    return s;
  endfunction

  function automatic status_t status_soft(input status_t cur);
    status_t s;
    s = status_cold();
    s.soft_flag = 1'b1;
    s.low_pwr   = cur.low_pwr;
    return s;
  endfunction

endpackage

// File: rtl/ctl_status.sv
module ctl_status
  import ctl_pkg::*;
(
  input  logic                clk,
  input  logic                cold_rst,
  input  logic                soft_rst,
  input  logic                wr_en,
  input  logic [STATUS_W-1:0] wr_data,
  output status_t             status_q
);

  always_ff @(posedge clk) begin
    if (cold_rst)      status_q <= status_cold();
    else if (soft_rst) status_q <= status_soft(status_q);
    else if (wr_en)    status_q <= status_t'(wr_data);
  end

  a_r2_soft_fields: assert property (@(posedge clk) disable iff (cold_rst)
    soft_rst |=> (status_q.boot_vec && status_q.err_lvl && status_q.soft_flag
                  && !status_q.nmi_flag && !status_q.tlb_shut));

  a_r2_soft_keeps_lowpwr: assert property (@(posedge clk) disable iff (cold_rst)
    soft_rst |=> status_q.low_pwr == $past(status_q.low_pwr));

endmodule

// File: rtl/ctl_index.sv
module ctl_index #(
  parameter int IDX_W   = 4,
  parameter int MAX_IDX = 15
) (
  input  logic             clk,
  input  logic             cold_rst,
  input  logic             soft_rst,
  input  logic             wired_we,
  input  logic [IDX_W-1:0] wired_wdata,
  output logic [IDX_W-1:0] index_q,
  output logic [IDX_W-1:0] wired_q
);

  localparam logic [IDX_W-1:0] TOP = IDX_W'(MAX_IDX);

  function automatic logic [IDX_W-1:0] next_index(input logic [IDX_W-1:0] cur,
                                                  input logic [IDX_W-1:0] floor_v);
    return (cur <= floor_v) ? TOP : cur - 1'b1;
  endfunction

  logic any_rst;
  logic wrap_evt;
  logic step_evt;
  assign any_rst  = cold_rst | soft_rst;
  assign wrap_evt = !any_rst && !wired_we && (index_q <= wired_q);
  assign step_evt = !any_rst && !wired_we && !(index_q <= wired_q);

  always_ff @(posedge clk) begin
    if (any_rst) begin
      index_q <= TOP;
      wired_q <= '0;
    end else if (wired_we) begin
      index_q <= TOP;
      wired_q <= wired_wdata;
    end else begin
      index_q <= next_index(index_q, wired_q);
    end
  end

  a_r3_soft_reload: assert property (@(posedge clk) disable iff (cold_rst)
    soft_rst |=> (index_q == TOP && wired_q == '0));

  a_r4_step_down: assert property (@(posedge clk) disable iff (cold_rst)
    step_evt |=> index_q == $past(index_q) - 1'b1);

  a_r4_wrap_top: assert property (@(posedge clk) disable iff (cold_rst)
    wrap_evt |=> index_q == TOP);

  a_r5_wired_reload: assert property (@(posedge clk) disable iff (cold_rst)
    (wired_we && !soft_rst) |=> (index_q == TOP && wired_q == $past(wired_wdata)));

endmodule

// File: rtl/ctl_cfgwatch.sv
module ctl_cfgwatch
  import ctl_pkg::*;
#(
  parameter int CFG_W = 4
) (
  input  logic             clk,
  input  logic             cold_rst,
  input  logic             soft_rst,
  input  logic [CFG_W-1:0] cfg_pins,
  input  logic             k0_we,
  input  logic             watch_we,
  input  logic [2:0]       wr_data,
  output logic [2:0]       k0_q,
  output logic [CFG_W-1:0] pins_q,
  output logic [2:0]       watch_q
);

  logic any_rst;
  assign any_rst = cold_rst | soft_rst;

  always_ff @(posedge clk) begin
    if (cold_rst) begin
      k0_q    <= K0_UNCACHED;
      watch_q <= '0;
    end else if (!soft_rst) begin
      if (k0_we)    k0_q    <= wr_data;
      if (watch_we) watch_q <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (any_rst) pins_q <= cfg_pins;
  end

  a_r6_soft_keeps_watch: assert property (@(posedge clk) disable iff (cold_rst)
    soft_rst |=> watch_q == $past(watch_q));

  a_r7_soft_keeps_k0: assert property (@(posedge clk) disable iff (cold_rst)
    soft_rst |=> k0_q == $past(k0_q));

  a_r7_pins_held: assert property (@(posedge clk) disable iff (cold_rst)
    !soft_rst |=> pins_q == $past(pins_q));

  a_r7_pins_capture: assert property (@(posedge clk) disable iff (cold_rst)
    soft_rst |=> pins_q == $past(cfg_pins));

endmodule

// File: rtl/ctl_regbank.sv
module ctl_regbank
  import ctl_pkg::*;
#(
  parameter int IDX_W   = 4,
  parameter int MAX_IDX = 15,
  parameter int CFG_W   = 4
) (
  input  logic              clk,
  input  logic              cold_rst,
  input  logic              soft_rst,
  input  logic [CFG_W-1:0]  cfg_pins,
  input  logic              sw_we,
  input  logic [ADDR_W-1:0] sw_addr,
  input  logic [DATA_W-1:0] sw_wdata,
  output logic [DATA_W-1:0] sw_rdata
);

  localparam int CFG_TOP = CFG_W + 3;

  status_t          status_q;
  logic [IDX_W-1:0] index_q;
  logic [IDX_W-1:0] wired_q;
  logic [2:0]       k0_q;
  logic [CFG_W-1:0] pins_q;
  logic [2:0]       watch_q;

  logic wr_status, wr_wired, wr_k0, wr_watch;
  assign wr_status = sw_we && (sw_addr == A_STATUS);
  assign wr_wired  = sw_we && (sw_addr == A_WIRED);
  assign wr_k0     = sw_we && (sw_addr == A_CONFIG);
  assign wr_watch  = sw_we && (sw_addr == A_WATCH);

  ctl_status u_status (
    .clk      (clk),
    .cold_rst (cold_rst),
    .soft_rst (soft_rst),
    .wr_en    (wr_status),
    .wr_data  (sw_wdata[STATUS_W-1:0]),
    .status_q (status_q)
  );

  ctl_index #(.IDX_W(IDX_W), .MAX_IDX(MAX_IDX)) u_index (
    .clk         (clk),
    .cold_rst    (cold_rst),
    .soft_rst    (soft_rst),
    .wired_we    (wr_wired),
    .wired_wdata (sw_wdata[IDX_W-1:0]),
    .index_q     (index_q),
    .wired_q     (wired_q)
  );

  ctl_cfgwatch #(.CFG_W(CFG_W)) u_cfg (
    .clk      (clk),
    .cold_rst (cold_rst),
    .soft_rst (soft_rst),
    .cfg_pins (cfg_pins),
    .k0_we    (wr_k0),
    .watch_we (wr_watch),
    .wr_data  (sw_wdata[2:0]),
    .k0_q     (k0_q),
    .pins_q   (pins_q),
    .watch_q  (watch_q)
  );

  always_comb begin
    sw_rdata = '0;
    case (sw_addr)
      A_STATUS: sw_rdata[STATUS_W-1:0] = status_q;
      A_INDEX:  sw_rdata[IDX_W-1:0]    = index_q;
      A_WIRED:  sw_rdata[IDX_W-1:0]    = wired_q;
      A_CONFIG: sw_rdata[CFG_TOP-1:0]  = {pins_q, k0_q};
      A_WATCH:  sw_rdata[2:0]          = watch_q;
      default:  sw_rdata = '0;
    endcase
  end

  // R8: cold wins when both resets are high
  a_r8_cold_priority: assert property (@(posedge clk)
    (cold_rst && soft_rst) |=> (status_q == status_cold() && watch_q == 3'b000
                                && k0_q == K0_UNCACHED));

  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (cold_rst)
    (sw_addr > A_WATCH) |-> sw_rdata == '0);

endmodule

// File: tb/sim_ctl_regbank.sv
`timescale 1ns/1ps
module sim_ctl_regbank;

  localparam int IDX_W   = 4;
  localparam int MAX_IDX = 11;
  localparam int CFG_W   = 4;

  logic             clk = 1'b0;
  logic             cold_rst = 1'b1;
  logic             soft_rst = 1'b0;
  logic [CFG_W-1:0] cfg_pins = 4'hA;
  logic             sw_we = 1'b0;
  logic [2:0]       sw_addr = 3'd0;
  logic [31:0]      sw_wdata = '0;
  logic [31:0]      sw_rdata;

  int checks = 0;
  int fails  = 0;
  int exp_idx, exp_wired;

  always #2.5 clk = ~clk;

  ctl_regbank #(.IDX_W(IDX_W), .MAX_IDX(MAX_IDX), .CFG_W(CFG_W)) u0 (
    .clk(clk), .cold_rst(cold_rst), .soft_rst(soft_rst), .cfg_pins(cfg_pins),
    .sw_we(sw_we), .sw_addr(sw_addr), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata)
  );

  function automatic int idx_after(input int cur, input int fl, input bit wr);
    if (wr) return MAX_IDX;
    if (cur <= fl) return MAX_IDX;
    return cur - 1;
  endfunction

  function automatic int cfg_word(input int pins, input int k0);
    return (pins << 3) | k0;
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input int addr, input int expv);
    sw_addr = addr[2:0];
    #0.5;
    checks++;
    if (sw_rdata !== 32'(expv)) begin
      fails++;
      $display("FAIL %s addr=%0d actual=0x%0h expected=0x%0h", req, addr, sw_rdata, expv);
    end
  endtask

  task automatic wr(input int addr, input int data);
    sw_we = 1'b1; sw_addr = addr[2:0]; sw_wdata = data;
    tick();
    sw_we = 1'b0;
  endtask

  initial begin
    #20000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd7781));
    tick(); tick();
    cold_rst = 1'b0;
    check("R1", 0, 'h03);
    check("R3", 2, 0);
    check("R3", 1, MAX_IDX);
    check("R7", 3, cfg_word('hA, 2));
    check("R6", 4, 0);
    check("R9", 5, 0);
    check("R9", 7, 0);

    // program fields, move the pins outside reset
    wr(0, 'h20);
    wr(4, 'h5);
    wr(3, 'h3);
    cfg_pins = 4'h6;
    wr(1, 'h4);  // index is read-only
    check("R9", 0, 'h20);
    check("R9", 4, 'h5);
    check("R7", 3, cfg_word('hA, 3));
    wr(2, 'h7);
    check("R5", 2, 7);
    check("R5", 1, MAX_IDX);

    // soft reset
    soft_rst = 1'b1; tick(); soft_rst = 1'b0;
    check("R2", 0, 'h27);
    check("R6", 4, 'h5);
    check("R7", 3, cfg_word('h6, 3));
    check("R3", 2, 0);
    check("R3", 1, MAX_IDX);

    // random walk of index and wired
    exp_idx = MAX_IDX; exp_wired = 0;
    for (int i = 0; i < 400; i++) begin
      bit doit;
      int v;
      doit = ($urandom % 8) == 0;
      v = $urandom % (MAX_IDX + 1);
      if (i == 5)  begin doit = 1'b1; v = 0; end
      if (i == 50) begin doit = 1'b1; v = MAX_IDX; end
      sw_we = doit; sw_addr = doit ? 3'd2 : 3'd1; sw_wdata = v;
      tick();
      sw_we = 1'b0;
      exp_idx = idx_after(exp_idx, exp_wired, doit);
      if (doit) exp_wired = v;
      check(doit ? "R5" : "R4", 1, exp_idx);
    end
    check("R5", 2, exp_wired);

    // both resets together
    wr(0, 'h3C);
    wr(4, 'h7);
    wr(3, 'h1);
    cfg_pins = 4'h9;
    cold_rst = 1'b1; soft_rst = 1'b1; tick();
    cold_rst = 1'b0; soft_rst = 1'b0;
    check("R8", 0, 'h03);
    check("R8", 4, 0);
    check("R8", 3, cfg_word('h9, 2));
    check("R8", 1, MAX_IDX);

    // low-power set, cold reset alone clears it
    wr(0, 'h20);
    cold_rst = 1'b1; tick(); cold_rst = 1'b0;
    check("R1", 0, 'h03);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule